// File: doc/BRIEF.md
# BCD On-Delay Countdown Timer

This block delays a control condition by a programmable time. The delay is given as a four-digit packed BCD word in tenths of a second, so the range runs from 000.0 s to 999.9 s. While the condition input stays true, a present value counts down from that preset by one count per 0.1 s tick. When it reaches zero, a done flag rises and stays up for as long as the condition stays true.

If the condition falls before the delay has run out, the present value returns to the preset. The next rising edge of the condition starts a complete new delay. The preset is captured on that rising edge, so changing it during a running delay does not alter that delay.

The tick can come from outside the block. It can also be produced inside the block by a prescaler, which is chosen with a parameter. A preset that holds a nibble outside 0 to 9 is flagged as an error, and no timing takes place.

Top module: `bcd_ondelay_timer`

## Requirements
- R1: During reset, `pv_bcd` is 0x0000 and both `done` and `preset_err` are 0.
- R2: On the clock edge after any edge where `cond_in` is 0, `pv_bcd` equals the `preset_bcd` value sampled at that edge, and `done` and `preset_err` are 0.
- R3: On a rising edge of `cond_in`, `preset_bcd` is captured into `pv_bcd`. Later changes to `preset_bcd` have no effect while `cond_in` stays 1.
- R4: While `cond_in` stays 1, `pv_bcd` falls by exactly one BCD count on each tick and holds between ticks. The borrow ripples across all digits, so 0x1000 becomes 0x0999 and every nibble stays within 0 to 9. Digit 0, bits 3:0, holds tenths of a second.
- R5: `done` rises on the N-th tick after the rising edge of `cond_in`, where N is the decimal value of the preset. A tick that arrives in the same cycle as the rising edge is ignored.
- R6: Once `done` is 1, it stays 1 and `pv_bcd` stays 0x0000 for as long as `cond_in` stays 1, whatever ticks arrive.
- R7: If `cond_in` falls before `done` rises, `pv_bcd` reloads the preset. The next rising edge then needs the full N ticks again.
- R8: A preset of 0x0000 makes `done` rise on the first tick after the rising edge of `cond_in`.
- R9: If any nibble of the captured preset is 10 to 15, `preset_err` rises on the cycle after the rising edge. While `cond_in` stays 1, `pv_bcd` then holds the captured value and `done` stays 0.
- R10: When `PRESCALE_DIV` is greater than 1, the internal tick occurs once for every `PRESCALE_DIV` clock cycles in which `tick_in` is 1. With `tick_in` held at 1 and a preset of 3, `done` rises 9 to 12 clocks after the rising edge of `cond_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | 0.1 s tick pulse; acts as the prescaler enable when the prescaler is built |
| cond_in | input | 1 | Enable condition that starts and holds the delay |
| preset_bcd | input | 16 | Set value as four BCD digits, in tenths of a second |
| pv_bcd | output | 16 | Present value as four BCD digits |
| done | output | 1 | High once the delay has expired while the condition is held |
| preset_err | output | 1 | High when the captured preset holds a nibble that is not BCD |

## Verification
The bench counts a preset of 12 down to zero. This catches a timer that finishes one tick late by waiting for the present value to read zero before raising done. It also drives a tick in the same cycle as the condition's rising edge, which a design that counts during the load cycle would turn into an early finish.

Presets of 1000 and 100 expose a borrow that fails to ripple past a zero digit; such a design would show hexadecimal digits or drop a whole decade. Dropping the condition part-way through a delay catches a design that resumes instead of restarting. A preset with a nibble of A shows whether a bad preset is still counted, and a zero preset shows whether done arrives without any tick at all.

// File: rtl/bcdt_pkg.sv
package bcdt_pkg;
  localparam int NUM_DIGITS = 4;
  localparam int WORD_W     = 4 * NUM_DIGITS;

  typedef logic [WORD_W-1:0] bcd_word_t;

  // True when every nibble of the word is a decimal digit.
  function automatic logic bcd_valid(input bcd_word_t v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  // True when the word holds the count one (last step before expiry).
  function automatic logic bcd_is_unit(input bcd_word_t v);
    return v == bcd_word_t'(1);
  endfunction
endpackage

// File: rtl/bcdt_digit_dec.sv
module bcdt_digit_dec (
  input  logic [3:0] din,
  input  logic       borrow_in,
  output logic [3:0] dout,
  output logic       borrow_out
);
  always_comb begin
    if (!borrow_in) begin
      dout       = din;
      borrow_out = 1'b0;
    end else if (din == 4'd0) begin
      dout       = 4'd9;
      borrow_out = 1'b1;
    end else begin
      dout       = din - 4'd1;
      borrow_out = 1'b0;
    end
  end
endmodule

// File: rtl/bcdt_dec_chain.sv
module bcdt_dec_chain #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] val_in,
  output logic [4*DIGITS-1:0] val_out,
  output logic                wrap_out
);
  logic [DIGITS:0] borrow;

  assign borrow[0] = 1'b1;

  generate
    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
      bcdt_digit_dec u_digit (
        .din        (val_in[4*g +: 4]),
        .borrow_in  (borrow[g]),
        .dout       (val_out[4*g +: 4]),
        .borrow_out (borrow[g+1])
      );
    end
  endgenerate

  // A borrow out of the top digit means the input was all zeros.
  assign wrap_out = borrow[DIGITS];
endmodule

// File: rtl/bcd_ondelay_timer.sv
module bcd_ondelay_timer
  import bcdt_pkg::*;
#(
  parameter int PRESCALE_DIV = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              cond_in,
  input  logic [WORD_W-1:0] preset_bcd,
  output logic [WORD_W-1:0] pv_bcd,
  output logic              done,
  output logic              preset_err
);
  // Named internal events, observed by the bound checker.
  logic              tick_w;
  logic              cond_q;
  logic              rise_w;
  logic              step_w;
  logic [WORD_W-1:0] pv_dec;
  logic              pv_zero;
  logic              pv_unit;
  logic              preset_ok;

  generate
    if (PRESCALE_DIV > 1) begin : g_presc
      localparam int CW = $clog2(PRESCALE_DIV);
      logic [CW-1:0] div_cnt;
      logic          div_hit;
      assign div_hit = (div_cnt == CW'(PRESCALE_DIV - 1));
      always_ff @(posedge clk) begin
        if (!rst_n) div_cnt <= '0;
        else if (tick_in) div_cnt <= div_hit ? '0 : div_cnt + CW'(1);
      end
      assign tick_w = tick_in & div_hit;
    end else begin : g_direct
      assign tick_w = tick_in;
    end
  endgenerate

  bcdt_dec_chain #(.DIGITS(NUM_DIGITS)) u_dec (
    .val_in   (pv_bcd),
    .val_out  (pv_dec),
    .wrap_out (pv_zero)
  );

  assign pv_unit   = bcd_is_unit(pv_bcd);
  assign preset_ok = bcd_valid(preset_bcd);
  assign rise_w    = cond_in & ~cond_q;
  assign step_w    = cond_in & cond_q & tick_w & ~preset_err & ~done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q     <= 1'b0;
      pv_bcd     <= '0;
      done       <= 1'b0;
      preset_err <= 1'b0;
    end else begin
      cond_q <= cond_in;
      if (!cond_in) begin
        pv_bcd     <= preset_bcd;
        done       <= 1'b0;
        preset_err <= 1'b0;
      end else if (rise_w) begin
        pv_bcd     <= preset_bcd;
        done       <= 1'b0;
        preset_err <= ~preset_ok;
      end else if (step_w) begin
        if (!pv_zero) pv_bcd <= pv_dec;
        done <= pv_zero | pv_unit;
      end
    end
  end
endmodule

// File: rtl/bcdt_checker.sv
module bcdt_checker
  import bcdt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cond_in,
  input logic              cond_q,
  input logic              tick_w,
  input logic [WORD_W-1:0] preset_bcd,
  input logic [WORD_W-1:0] pv_bcd,
  input logic              done,
  input logic              preset_err
);
  AST_IDLE_TRACKS_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_in |=> (pv_bcd == $past(preset_bcd) && !done && !preset_err)); // R2
  AST_LOAD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_in && !cond_q) |=> (pv_bcd == $past(preset_bcd) && !done)); // R3
  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_in && cond_q && !tick_w) |=> ($stable(pv_bcd) && $stable(done))); // R4
  AST_PV_DIGITS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cond_in) && !preset_err) |-> bcd_valid(pv_bcd)); // R4
  AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(tick_w)); // R5
  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pv_bcd == '0)); // R6
  AST_ERR_BLOCKS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    preset_err |-> !done); // R9
endmodule

bind bcd_ondelay_timer bcdt_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cond_in    (cond_in),
  .cond_q     (cond_q),
  .tick_w     (tick_w),
  .preset_bcd (preset_bcd),
  .pv_bcd     (pv_bcd),
  .done       (done),
  .preset_err (preset_err)
);

// File: tb/bcd_ondelay_timer_tb.sv
`timescale 1ns/1ps
module bcd_ondelay_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n, tick, cond;
  logic [15:0] preset;
  logic [15:0] pv, ps_pv;
  logic        done, err, ps_done, ps_err;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  bcd_ondelay_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick), .cond_in(cond),
    .preset_bcd(preset), .pv_bcd(pv), .done(done), .preset_err(err));

  bcd_ondelay_timer #(.PRESCALE_DIV(4)) u_ps (
    .clk(clk), .rst_n(rst_n), .tick_in(1'b1), .cond_in(cond),
    .preset_bcd(preset), .pv_bcd(ps_pv), .done(ps_done), .preset_err(ps_err));

  function automatic logic [15:0] to_bcd(input int n);
    logic [15:0] r;
    int v;
    v = n;
    for (int i = 0; i < 4; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick1();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic go_high(input logic [15:0] p);
    preset = p;
    cond = 1'b1;
    @(negedge clk);
  endtask

  task automatic drop();
    cond = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cond = 1'b0; tick = 1'b0; preset = 16'h0000;
    repeat (3) @(negedge clk);
    chk("R1 pv", pv, 16'h0000);
    chk("R1 done", {15'd0, done}, 16'd0);
    chk("R1 err", {15'd0, err}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_idle();
    preset = 16'h1234;
    @(negedge clk);
    chk("R2 pv follows preset", pv, 16'h1234);
    tick1();
    chk("R2 tick ignored while idle", pv, 16'h1234);
    chk("R2 done low", {15'd0, done}, 16'd0);
  endtask

  task automatic t_count();
    preset = 16'h0012; cond = 1'b1; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk("R5 tick in rise cycle ignored", pv, 16'h0012);
    preset = 16'h0500;
    for (int k = 1; k <= 11; k++) begin
      tick1();
      chk("R4 countdown", pv, to_bcd(12 - k));
      chk("R5 not yet done", {15'd0, done}, 16'd0);
    end
    chk("R3 preset change ignored", pv, 16'h0001);
    repeat (3) @(negedge clk);
    chk("R4 hold between ticks", pv, 16'h0001);
    tick1();
    chk("R5 done on Nth tick", {15'd0, done}, 16'd1);
    chk("R5 pv zero", pv, 16'h0000);
    repeat (3) tick1();
    chk("R6 done held", {15'd0, done}, 16'd1);
    chk("R6 pv held at zero", pv, 16'h0000);
    drop();
    chk("R2 done clears", {15'd0, done}, 16'd0);
    chk("R2 pv reloads", pv, 16'h0500);
  endtask

  task automatic t_borrow();
    go_high(16'h1000);
    tick1();
    chk("R4 borrow through three digits", pv, 16'h0999);
    tick1();
    chk("R4 next step", pv, 16'h0998);
    drop();
    go_high(16'h0100);
    tick1();
    chk("R4 borrow through two digits", pv, 16'h0099);
    drop();
    go_high(16'h0010);
    tick1();
    chk("R4 borrow one digit", pv, 16'h0009);
    drop();
  endtask

  task automatic t_abort();
    go_high(16'h0005);
    repeat (3) tick1();
    chk("R7 partial count", pv, 16'h0002);
    drop();
    chk("R7 pv reloads on drop", pv, 16'h0005);
    chk("R7 done low", {15'd0, done}, 16'd0);
    go_high(16'h0005);
    repeat (4) tick1();
    chk("R7 full count needed", {15'd0, done}, 16'd0);
    chk("R7 pv after 4", pv, 16'h0001);
    tick1();
    chk("R7 done after full count", {15'd0, done}, 16'd1);
    drop();
  endtask

  task automatic t_zero();
    go_high(16'h0000);
    chk("R8 not done before tick", {15'd0, done}, 16'd0);
    tick1();
    chk("R8 done on first tick", {15'd0, done}, 16'd1);
    chk("R8 pv zero", pv, 16'h0000);
    drop();
  endtask

  task automatic t_bad();
    go_high(16'h00A3);
    chk("R9 err raised", {15'd0, err}, 16'd1);
    chk("R9 pv captured", pv, 16'h00A3);
    repeat (4) tick1();
    chk("R9 pv holds", pv, 16'h00A3);
    chk("R9 done stays low", {15'd0, done}, 16'd0);
    drop();
    chk("R9 err clears when idle", {15'd0, err}, 16'd0);
    go_high(16'hF000);
    chk("R9 err on top nibble", {15'd0, err}, 16'd1);
    drop();
  endtask

  task automatic t_presc();
    int first;
    first = 0;
    preset = 16'h0003;
    @(negedge clk);
    cond = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (ps_done && first == 0) first = k;
    end
    checks++;
    if (first < 9 || first > 12) begin
      errors++;
      $display("FAIL R10 prescaled delay: actual %0d expected 9..12", first);
    end
    chk("R10 pv zero at end", ps_pv, 16'h0000);
    drop();
  endtask

  initial begin
    t_reset();
    t_idle();
    t_count();
    t_borrow();
    t_abort();
    t_zero();
    t_bad();
    t_presc();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule